// File: doc/BRIEF.md
# Dual-Channel Asynchronous Serial Link with Message Tag Filter

This block provides a set of independent one-wire asynchronous serial channels, two by default. Each channel has a transmitter and a receiver that share a per-channel configuration: the bit period in system clocks, a byte or word frame format, the line polarity, and a 4-bit message tag. The transmitter takes a one-cycle load strobe with a data word and a destination tag, then reports busy until the frame is fully on the wire. The receiver delivers a one-cycle valid pulse with the received word, or a one-cycle framing-error pulse.

Two frame formats exist. The byte frame has a start bit, 8 data bits and one stop bit, with either line polarity. The word frame has a start bit, 32 data bits and one stop bit, and always uses the inverted line polarity. When tagging is enabled, 4 tag bits follow the data bits. A receiver with tagging enabled only accepts frames whose tag equals its own configured tag, so several listeners can share one wire.

Configuration inputs are sampled when a frame starts. They are meant to change only while the channel is held in reset. Otherwise the idle level of the line moves, and a receiver would see that change as a start bit.

Top module: `ser_link`

## Requirements
- R1: While reset is high and on the first cycle after it, every channel shows tx_busy=0, rx_valid=0, rx_ferr=0, and tx_pin at the idle level of its configuration.
- R2: A load strobe on an idle channel raises tx_busy on the next cycle. From that cycle the frame is driven one bit per period: start, data LSB first, tag bits LSB first when enabled, and stop. tx_busy falls exactly (frame bits × period) cycles after it rose.
- R3: Line levels. For a byte frame with cfg_neg=0, the line idles high, the start bit is low, the stop bit is high and data bits appear unchanged. For cfg_neg=1 all levels, data included, are inverted.
- R4: A load strobe while tx_busy is high is ignored. The frame in flight and its busy time are unchanged.
- R5: The bit period is cfg_period clocks for any value from 1 to 65535. A value of 0 behaves as 1.
- R6: The receiver passes the line through a two-stage synchronizer. It detects the start level, samples each later bit floor(period/2) clocks into the bit, and pulses rx_valid for one cycle with the data. A byte frame's data is zero-extended to 32 bits.
- R7: With tagging enabled, the 4 tag bits sit between the data and the stop bit. The receiver raises rx_valid only when the received tag equals cfg_tag. A frame with a mismatched tag and a good stop bit produces no output at all.
- R8: If the stop bit is sampled at the start level, rx_ferr pulses for one cycle and rx_valid stays low. The receiver then accepts no new start until it has seen the idle level.
- R9: Each channel's transmitter and receiver run from that channel's own configuration. Activity on one channel does not alter another channel's outputs.
- R10: With cfg_wide=1 the frame carries 32 data bits and uses the inverted polarity regardless of cfg_neg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | NCH*PW | Per-channel clocks per bit |
| cfg_wide | input | NCH | Per-channel 32-bit frame select |
| cfg_neg | input | NCH | Per-channel inverted polarity (byte frames) |
| cfg_tag_en | input | NCH | Per-channel tag insertion and filtering enable |
| cfg_tag | input | NCH*4 | Per-channel local tag for receive filtering |
| tx_load | input | NCH | Start-frame strobe |
| tx_data | input | NCH*32 | Word to transmit |
| tx_tag | input | NCH*4 | Destination tag placed in the frame |
| tx_busy | output | NCH | Transmitter frame in progress |
| tx_pin | output | NCH | Serial output line |
| rx_pin | input | NCH | Serial input line |
| rx_valid | output | NCH | One-cycle received-frame pulse |
| rx_data | output | NCH*32 | Received word |
| rx_ferr | output | NCH | One-cycle framing-error pulse |

## Verification
The bench builds the block with the default two channels and 16-bit period counters. It cross-connects the channels so that each transmitter feeds the other channel's receiver, and it can also drive either receive line directly. It uses periods of 0, 1, 2, 3, 4, 5 and 6, which covers the zero-as-one rule, the degenerate one-clock bit where the sample point falls on the start edge, and both odd and even mid-bit offsets. Periods near the 65535 limit are not exercised because of run length. Driving the line directly allows bad stop bits, a line held at the active level after an error, and two channels transmitting at different rates at the same time.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int NARROW    = 8;
  localparam int WIDE      = 32;
  localparam int TAGW      = 4;
  localparam int FRAME_MAX = WIDE + TAGW + 2;
  localparam int CNTW      = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {RX_ARM, RX_HUNT, RX_SHIFT} rx_state_e;

  // level that marks a start bit on the wire
  function automatic logic active_pol(input logic wide, input logic neg);
    return wide | neg;
  endfunction

  // data plus tag bits, excluding start and stop
  function automatic logic [CNTW-1:0] payload_bits(input logic wide, input logic tag_en);
    logic [CNTW-1:0] n;
    n = wide ? CNTW'(WIDE) : CNTW'(NARROW);
    if (tag_en) n = n + CNTW'(TAGW);
    return n;
  endfunction

  // logical frame, bit 0 first on the wire; positions past the stop stay 1
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [WIDE-1:0] d,
                                                       input logic wide,
                                                       input logic tag_en,
                                                       input logic [TAGW-1:0] t);
    logic [FRAME_MAX-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < WIDE; i++)
      if (wide || i < NARROW) f[i+1] = d[i];
    for (int i = 0; i < TAGW; i++)
      if (tag_en) begin
        if (wide) f[WIDE+1+i] = t[i];
        else      f[NARROW+1+i] = t[i];
      end
    return f;
  endfunction
endpackage

// File: rtl/ser_tx.sv
module ser_tx
  import ser_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PW-1:0]   period,
  input  logic            wide,
  input  logic            neg,
  input  logic            tag_en,
  input  logic            load,
  input  logic [WIDE-1:0] data,
  input  logic [TAGW-1:0] tag,
  output logic            busy,
  output logic            pin
);
  logic [FRAME_MAX-1:0] shreg;
  logic [FRAME_MAX-1:0] frame;
  logic [PW-1:0]        cnt;
  logic [PW-1:0]        per_q;
  logic [PW-1:0]        eff;
  logic [CNTW-1:0]      left;
  logic                 inv_q;
  logic                 pol;

  assign eff   = (period == '0) ? PW'(1) : period;
  assign pol   = active_pol(wide, neg);
  assign frame = build_frame(data, wide, tag_en, tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      pin   <= ~pol;
      shreg <= '0;
      cnt   <= '0;
      per_q <= '0;
      left  <= '0;
      inv_q <= 1'b0;
    end else if (!busy) begin
      pin <= ~pol;
      if (load) begin
        busy  <= 1'b1;
        pin   <= frame[0] ^ pol;
        shreg <= frame >> 1;
        per_q <= eff;
        cnt   <= eff - 1'b1;
        left  <= payload_bits(wide, tag_en) + CNTW'(2);
        inv_q <= pol;
      end
    end else if (cnt == '0) begin
      if (left == CNTW'(1)) begin
        busy <= 1'b0;
        pin  <= ~pol;
      end else begin
        pin   <= shreg[0] ^ inv_q;
        shreg <= shreg >> 1;
        left  <= left - 1'b1;
        cnt   <= per_q - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ser_rx.sv
module ser_rx
  import ser_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PW-1:0]   period,
  input  logic            wide,
  input  logic            neg,
  input  logic            tag_en,
  input  logic [TAGW-1:0] my_tag,
  input  logic            pin,
  output logic            valid,
  output logic [WIDE-1:0] data,
  output logic            ferr
);
  localparam int ACCW = WIDE + TAGW;

  rx_state_e        state;
  logic [1:0]       sync;
  logic [PW:0]      cnt;
  logic [PW-1:0]    per_q;
  logic [PW-1:0]    eff;
  logic [CNTW-1:0]  idx;
  logic [CNTW-1:0]  last_q;
  logic [ACCW-1:0]  acc;
  logic             inv_q;
  logic             wide_q;
  logic             tagen_q;
  logic             lvl_now;
  logic             bitv;
  logic [TAGW-1:0]  got_tag;

  assign eff     = (period == '0) ? PW'(1) : period;
  assign lvl_now = sync[1] ^ active_pol(wide, neg);
  assign bitv    = sync[1] ^ inv_q;
  assign got_tag = wide_q ? acc[WIDE +: TAGW] : acc[NARROW +: TAGW];

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[0], pin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_ARM;
      valid   <= 1'b0;
      ferr    <= 1'b0;
      data    <= '0;
      cnt     <= '0;
      per_q   <= '0;
      idx     <= '0;
      last_q  <= '0;
      acc     <= '0;
      inv_q   <= 1'b0;
      wide_q  <= 1'b0;
      tagen_q <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      case (state)
        RX_ARM: if (lvl_now) state <= RX_HUNT;
        RX_HUNT: begin
          if (!lvl_now) begin
            state   <= RX_SHIFT;
            per_q   <= eff;
            cnt     <= {1'b0, eff >> 1} + {1'b0, eff} - 1'b1;
            idx     <= '0;
            last_q  <= payload_bits(wide, tag_en);
            inv_q   <= active_pol(wide, neg);
            wide_q  <= wide;
            tagen_q <= tag_en;
          end
        end
        RX_SHIFT: begin
          if (cnt == '0) begin
            if (idx == last_q) begin
              state <= RX_ARM;
              if (!bitv) ferr <= 1'b1;
              else if (!tagen_q || got_tag == my_tag) begin
                valid <= 1'b1;
                data  <= wide_q ? acc[WIDE-1:0] : {{(WIDE-NARROW){1'b0}}, acc[NARROW-1:0]};
              end
            end else begin
              acc[idx] <= bitv;
              idx      <= idx + 1'b1;
              cnt      <= {1'b0, per_q} - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= RX_ARM;
      endcase
    end
  end
endmodule

// File: rtl/ser_link.sv
module ser_link
  import ser_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH*PW-1:0]   cfg_period,
  input  logic [NCH-1:0]      cfg_wide,
  input  logic [NCH-1:0]      cfg_neg,
  input  logic [NCH-1:0]      cfg_tag_en,
  input  logic [NCH*TAGW-1:0] cfg_tag,
  input  logic [NCH-1:0]      tx_load,
  input  logic [NCH*WIDE-1:0] tx_data,
  input  logic [NCH*TAGW-1:0] tx_tag,
  output logic [NCH-1:0]      tx_busy,
  output logic [NCH-1:0]      tx_pin,
  input  logic [NCH-1:0]      rx_pin,
  output logic [NCH-1:0]      rx_valid,
  output logic [NCH*WIDE-1:0] rx_data,
  output logic [NCH-1:0]      rx_ferr
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ser_tx #(.PW(PW)) u_tx (
      .clk   (clk),
      .rst   (rst),
      .period(cfg_period[c*PW +: PW]),
      .wide  (cfg_wide[c]),
      .neg   (cfg_neg[c]),
      .tag_en(cfg_tag_en[c]),
      .load  (tx_load[c]),
      .data  (tx_data[c*WIDE +: WIDE]),
      .tag   (tx_tag[c*TAGW +: TAGW]),
      .busy  (tx_busy[c]),
      .pin   (tx_pin[c])
    );
    ser_rx #(.PW(PW)) u_rx (
      .clk   (clk),
      .rst   (rst),
      .period(cfg_period[c*PW +: PW]),
      .wide  (cfg_wide[c]),
      .neg   (cfg_neg[c]),
      .tag_en(cfg_tag_en[c]),
      .my_tag(cfg_tag[c*TAGW +: TAGW]),
      .pin   (rx_pin[c]),
      .valid (rx_valid[c]),
      .data  (rx_data[c*WIDE +: WIDE]),
      .ferr  (rx_ferr[c])
    );
  end
endmodule

// File: rtl/ser_link_chk.sv
module ser_link_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] cfg_wide,
  input logic [NCH-1:0] cfg_neg,
  input logic [NCH-1:0] tx_load,
  input logic [NCH-1:0] tx_busy,
  input logic [NCH-1:0] tx_pin,
  input logic [NCH-1:0] rx_valid,
  input logic [NCH-1:0] rx_ferr
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2: a frame only begins after a load strobe
    p_busy_needs_load_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_busy[c]) |-> $past(tx_load[c]));

    // R3: first bit on the wire carries the start level of the config seen at load
    p_start_level_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_busy[c]) |-> tx_pin[c] == ($past(cfg_wide[c]) | $past(cfg_neg[c])));

    // R3 R10: an idle line rests at the inactive level
    p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
      (!tx_busy[c] && $stable(cfg_wide[c]) && $stable(cfg_neg[c]))
        |-> tx_pin[c] == ~(cfg_wide[c] | cfg_neg[c]));

    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      rx_valid[c] |=> !rx_valid[c]);

    // R8: error is a single-cycle pulse and never joins a valid
    p_ferr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      rx_ferr[c] |=> !rx_ferr[c]);
    p_ferr_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(rx_ferr[c] && rx_valid[c]));
  end
endmodule

bind ser_link ser_link_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_wide(cfg_wide),
  .cfg_neg (cfg_neg),
  .tx_load (tx_load),
  .tx_busy (tx_busy),
  .tx_pin  (tx_pin),
  .rx_valid(rx_valid),
  .rx_ferr (rx_ferr)
);

// File: tb/sim_ser_link.sv
module sim_ser_link;
  localparam int CLK_NS = 10;
  localparam int NCH    = 2;
  localparam int PW     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic [NCH*PW-1:0] cfg_period;
  logic [NCH-1:0]    cfg_wide, cfg_neg, cfg_tag_en;
  logic [NCH*4-1:0]  cfg_tag;
  logic [NCH-1:0]    tx_load;
  logic [NCH*32-1:0] tx_data;
  logic [NCH*4-1:0]  tx_tag;
  logic [NCH-1:0]    tx_busy, tx_pin, rx_pin, rx_valid, rx_ferr;
  logic [NCH*32-1:0] rx_data;
  logic [NCH-1:0]    rx_sel, rx_drv;

  assign rx_pin[0] = rx_sel[0] ? rx_drv[0] : tx_pin[1];
  assign rx_pin[1] = rx_sel[1] ? rx_drv[1] : tx_pin[0];

  ser_link #(.NCH(NCH), .PW(PW)) u0 (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_wide(cfg_wide),
    .cfg_neg(cfg_neg), .cfg_tag_en(cfg_tag_en), .cfg_tag(cfg_tag),
    .tx_load(tx_load), .tx_data(tx_data), .tx_tag(tx_tag), .tx_busy(tx_busy),
    .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_on = 0;
  string cur_req = "R1";
  logic [1:0] q0[$];
  logic [1:0] q1[$];
  logic fbits[$];
  logic [NCH-1:0] idle_ref;
  int exp_at[NCH];
  int exp_kind[NCH];            // 0 none, 1 valid, 2 framing error
  logic [31:0] exp_dat[NCH];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic int qsize(input int c);
    return (c == 0) ? q0.size() : q1.size();
  endfunction
  function automatic logic [1:0] qfront(input int c);
    return (c == 0) ? q0[0] : q1[0];
  endfunction
  function automatic void qpush(input int c, input logic [1:0] v);
    if (c == 0) q0.push_back(v); else q1.push_back(v);
  endfunction

  function automatic int per(input int c);
    int p;
    p = int'(cfg_period[c*PW +: PW]);
    return (p == 0) ? 1 : p;
  endfunction
  function automatic logic pol(input int c);
    return cfg_wide[c] | cfg_neg[c];
  endfunction

  // logical frame bits, first on the wire first
  function automatic void make_bits(input int c, input logic [31:0] d, input logic [3:0] t);
    int dn;
    dn = cfg_wide[c] ? 32 : 8;
    fbits.delete();
    fbits.push_back(1'b0);
    for (int i = 0; i < dn; i++) fbits.push_back(d[i]);
    if (cfg_tag_en[c]) for (int i = 0; i < 4; i++) fbits.push_back(t[i]);
    fbits.push_back(1'b1);
  endfunction

  function automatic void expect_rx(input int dst, input int e0, input int p, input int n,
                                    input logic [31:0] d, input logic [3:0] t, input bit bad);
    bit match;
    match = !cfg_tag_en[dst] || (t == cfg_tag[dst*4 +: 4]);
    exp_at[dst]   = e0 + 2 + p/2 + (n-1)*p;
    exp_kind[dst] = bad ? 2 : (match ? 1 : 0);
    exp_dat[dst]  = cfg_wide[dst] ? d : {24'h0, d[7:0]};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NCH; c++) idle_ref[c] <= ~(cfg_wide[c] | cfg_neg[c]);
  end

  always @(negedge clk) begin
    logic [1:0] e;
    logic ep;
    bit ev;
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        e = 2'b00;
        if (c == 0 && q0.size() > 0) e = q0.pop_front();
        if (c == 1 && q1.size() > 0) e = q1.pop_front();
        ep = e[1] ? e[0] : idle_ref[c];
        chk(tx_busy[c] == e[1], "tx_busy", 32'(tx_busy[c]), 32'(e[1]));
        chk(tx_pin[c] == ep, "tx_pin", 32'(tx_pin[c]), 32'(ep));
        ev = (cyc == exp_at[c]);
        chk(rx_valid[c] == (ev && exp_kind[c] == 1), "rx_valid", 32'(rx_valid[c]),
            32'(ev && exp_kind[c] == 1));
        chk(rx_ferr[c] == (ev && exp_kind[c] == 2), "rx_ferr", 32'(rx_ferr[c]),
            32'(ev && exp_kind[c] == 2));
        if (ev && exp_kind[c] == 1)
          chk(rx_data[c*32 +: 32] == exp_dat[c], "rx_data", rx_data[c*32 +: 32], exp_dat[c]);
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // load channel c; its frame is expected at receiver dst (or nowhere if dst < 0)
  task automatic send(input int c, input logic [31:0] d, input logic [3:0] t, input int dst);
    int p, n;
    bit take;
    logic pl;
    p = per(c);
    pl = pol(c);
    make_bits(c, d, t);
    n = fbits.size();
    take = (qsize(c) == 0) || (qsize(c) == 1 && qfront(c)[1] == 1'b0);
    tx_load[c] = 1'b1;
    tx_data[c*32 +: 32] = d;
    tx_tag[c*4 +: 4] = t;
    if (take) begin
      if (qsize(c) == 0) qpush(c, 2'b00);
      for (int b = 0; b < n; b++)
        for (int k = 0; k < p; k++) qpush(c, {1'b1, fbits[b] ^ pl});
      if (dst >= 0) expect_rx(dst, cyc + 2, p, n, d, t, 1'b0);
    end
    step();
    tx_load[c] = 1'b0;
  endtask

  // drive receiver c directly, optionally with a bad stop held for extra cycles
  task automatic drive_raw(input int c, input logic [31:0] d, input logic [3:0] t,
                           input bit bad, input int tail);
    int p, n;
    logic pl;
    p = per(c);
    pl = pol(c);
    make_bits(c, d, t);
    n = fbits.size();
    if (bad) fbits[n-1] = 1'b0;
    expect_rx(c, cyc + 1, p, n, d, t, bad);
    for (int b = 0; b < n; b++) begin
      rx_drv[c] = fbits[b] ^ pl;
      step(p);
    end
    if (bad) begin
      rx_drv[c] = pl;
      step(tail);
    end
    rx_drv[c] = ~pl;
  endtask

  task automatic reconfig(input int p0, input int p1, input logic wide, input logic neg,
                          input logic ten, input logic [3:0] tg);
    rst = 1'b1;
    cfg_period = {PW'(p1), PW'(p0)};
    cfg_wide = {NCH{wide}};
    cfg_neg = {NCH{neg}};
    cfg_tag_en = {NCH{ten}};
    cfg_tag = {NCH{tg}};
    rx_drv = {NCH{~(wide | neg)}};
    for (int c = 0; c < NCH; c++) begin exp_at[c] = -1; exp_kind[c] = 0; end
    step(3);
    rst = 1'b0;
    step(2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    cur_req = "watchdog";
    chk(1'b0, "run did not complete", 32'(cyc), 32'd0);
    finish_run();
  end

  initial begin
    tx_load = '0; tx_data = '0; tx_tag = '0; rx_sel = '0;
    for (int c = 0; c < NCH; c++) begin exp_at[c] = -1; exp_kind[c] = 0; end
    cfg_period = {PW'(4), PW'(4)};
    cfg_wide = '0; cfg_neg = '0; cfg_tag_en = '0; cfg_tag = {4'h9, 4'h9};
    rx_drv = '1;
    step(3);
    @(negedge clk);
    cur_req = "R1";
    for (int c = 0; c < NCH; c++) begin
      chk(tx_busy[c] == 1'b0, "reset tx_busy", 32'(tx_busy[c]), 32'd0);
      chk(tx_pin[c] == 1'b1, "reset tx_pin", 32'(tx_pin[c]), 32'd1);
      chk(rx_valid[c] == 1'b0 && rx_ferr[c] == 1'b0, "reset rx flags",
          32'({rx_valid[c], rx_ferr[c]}), 32'd0);
    end
    step();
    rst = 1'b0;
    mon_on = 1;
    step(3);

    cur_req = "R2 R6";
    send(1, 32'hA5, 4'h0, 0); step(50);
    send(0, 32'h5A, 4'h0, 1); step(50);

    cur_req = "R3";
    reconfig(5, 5, 1'b0, 1'b1, 1'b0, 4'h9);
    send(1, 32'h3C, 4'h0, 0); step(60);

    cur_req = "R5";
    reconfig(1, 1, 1'b0, 1'b0, 1'b0, 4'h9);
    send(1, 32'h81, 4'h0, 0); step(20);
    reconfig(0, 0, 1'b0, 1'b0, 1'b0, 4'h9);
    send(0, 32'h7E, 4'h0, 1); step(20);

    cur_req = "R10";
    reconfig(3, 3, 1'b1, 1'b0, 1'b0, 4'h9);
    send(1, 32'hDEADBEEF, 4'h0, 0); step(110);
    send(0, 32'h12345678, 4'h0, 1); step(110);

    cur_req = "R7";
    reconfig(2, 2, 1'b0, 1'b0, 1'b1, 4'h9);
    send(1, 32'h66, 4'h9, 0); step(35);
    send(1, 32'h77, 4'h6, 0); step(35);
    reconfig(2, 2, 1'b1, 1'b0, 1'b1, 4'h9);
    send(0, 32'hCAFEF00D, 4'h9, 1); step(85);

    cur_req = "R4";
    reconfig(4, 4, 1'b0, 1'b0, 1'b0, 4'h9);
    send(1, 32'h11, 4'h0, 0); step(10);
    send(1, 32'h99, 4'h0, 0); step(50);

    cur_req = "R8";
    reconfig(3, 3, 1'b0, 1'b0, 1'b0, 4'h9);
    rx_sel[0] = 1'b1;
    step(2);
    drive_raw(0, 32'hC3, 4'h0, 1'b1, 7); step(10);
    drive_raw(0, 32'h3C, 4'h0, 1'b0, 0); step(10);
    rx_sel = '0;

    cur_req = "R9";
    reconfig(6, 4, 1'b0, 1'b0, 1'b0, 4'h9);
    rx_sel = '1;
    step(2);
    send(0, 32'h55, 4'h0, -1);
    send(1, 32'hAA, 4'h0, -1);
    step(70);
    drive_raw(1, 32'h96, 4'h0, 1'b0, 0); step(10);
    rx_sel = '0;

    step(5);
    finish_run();
  end
endmodule